// File: doc/BRIEF.md
# Ring-Oscillator Pair Comparison Sequencer

This block is the digital control side of a ring-oscillator fingerprint cell whose oscillation path is chosen by an 8-bit challenge. A challenge is shifted in one bit per clock and held in an 8-bit shift register that can also run as a linear feedback generator. After a start pulse, the block enables the oscillator for a timed window while a counter in the oscillator clock domain counts up. It then derives a second challenge, either by stepping the feedback register a chosen number of times or by taking a directly supplied value. In a second window of the same length the same counter counts down.

When the second window ends, the counter's sign bit shows which of the two oscillator paths ran faster. That bit is the response. The number of feedback steps is an input, so the mapping from challenge to response can be changed without touching the oscillator. The enable, clear and count-direction controls cross into the oscillator clock domain through two-stage synchronizers. The sign bit crosses back the same way, and fixed quiet intervals give each crossing time to settle.

Top module: `ro_pair_sequencer`

## Requirements
- R1: When reset is released, `osc_en`, `busy`, `done`, `resp` and `chal` are all zero.
- R2: The challenge register shifts only while the block is idle, `load_mode` is high and `start` is low. On each such clock it moves left by one and `ser_in` enters bit 0, so after eight such clocks `chal` equals the eight bits in the order they were sent, first bit as bit 7.
- R3: `osc_en` is never high while `busy` is low, including during challenge loading.
- R4: A start pulse in idle clears the counter, then holds `osc_en` high for exactly `win_len` system cycles (a value of 0 acts as 1). During that window `chal` holds the first challenge and the counter counts up on rising oscillator edges.
- R5: Without bypass, the challenge register then takes `step_cnt` feedback steps (a value of 0 means 10 steps). Each step shifts left with bit 0 set to bit7 XOR bit5 XOR bit4 XOR bit3. The result is the second challenge.
- R6: A second window of the same length then holds `osc_en` high with `chal` stable at the second challenge, and the counter counts down.
- R7: At the end, `done` pulses for one cycle in the cycle `busy` falls. `resp` is the counter's sign bit: 1 when the oscillator ran faster during the second window than during the first. `resp` holds its value until the next `done`.
- R8: With `bypass` high at start, the second challenge is `chal_b` instead of the stepped value.
- R9: If the challenge register is zero when a sequence starts, it is replaced by 8'hB4 before the first window.
- R10: A start pulse while `busy` is high has no effect: each sequence gives exactly two enable windows and one `done`.
- R11: `load_mode` and `ser_in` have no effect on the challenge register while `busy` is high.
- R12: `win_len`, `step_cnt`, `bypass` and `chal_b` are captured at start. Later changes do not affect the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a measurement sequence when idle |
| load_mode | input | 1 | Serial challenge load enable |
| ser_in | input | 1 | Serial challenge bit |
| bypass | input | 1 | Use `chal_b` as the second challenge |
| chal_b | input | 8 | Directly supplied second challenge |
| step_cnt | input | STEP_W | Feedback steps between windows (0 selects 10) |
| win_len | input | WIN_W | Window length in system cycles (0 acts as 1) |
| osc_clk | input | 1 | Ring-oscillator output used as a counting clock |
| osc_en | output | 1 | Oscillator enable, high during the two windows |
| chal | output | 8 | Challenge driving the oscillator path selection |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle end-of-sequence pulse |
| resp | output | 1 | Response bit (counter sign) |

## Verification
The bench models the oscillator with a half period that grows with the challenge value, so a smaller challenge always means a faster path. It tries challenge pairs in both orders, with the first path faster and then slower, over several window lengths. This shows that the response follows the sign of the up-minus-down count and not a fixed value. Stepped runs with explicit, zero and default step counts, together with a zero first challenge, separate the feedback taps, the default step substitution and the lock-up guard. Disturbance runs, with start pulses, serial load activity and changed setup inputs during a sequence, show that a running measurement cannot be altered.

// File: rtl/ro_pair_sequencer_pkg.sv
package ro_pair_sequencer_pkg;

  localparam int CHAL_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLR,
    ST_WIN_A,
    ST_GAP,
    ST_STEP,
    ST_SETB,
    ST_WIN_B,
    ST_TAIL
  } seq_state_t;

  // one feedback step, taps at 8,6,5,4
  function automatic logic [CHAL_W-1:0] lfsr_advance(input logic [CHAL_W-1:0] v);
    return {v[CHAL_W-2:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
  endfunction

endpackage

// File: rtl/rps_sync.sv
module rps_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;
  logic [W-1:0] s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end

  assign q = s2;
endmodule

// File: rtl/rps_chal_reg.sv
module rps_chal_reg
  import ro_pair_sequencer_pkg::*;
#(
  parameter logic [CHAL_W-1:0] ZERO_SUB = 8'hB4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              shift_bit,
  input  logic              fix_en,
  input  logic              step_en,
  input  logic              load_en,
  input  logic [CHAL_W-1:0] load_val,
  output logic [CHAL_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load_en) begin
      q <= load_val;
    end else if (fix_en) begin
      if (q == '0) q <= ZERO_SUB;
    end else if (step_en) begin
      q <= lfsr_advance(q);
    end else if (shift_en) begin
      q <= {q[CHAL_W-2:0], shift_bit};
    end
  end
endmodule

// File: rtl/rps_osc_counter.sv
module rps_osc_counter #(
  parameter int CNT_W = 20
) (
  input  logic osc_clk,
  input  logic rst,
  input  logic en,
  input  logic up,
  input  logic clr,
  output logic sign
);
  logic       rst_o;
  logic [2:0] ctl_s;
  logic [CNT_W-1:0] cnt;

  rps_sync #(.W(1)) u_rst_sync (
    .clk(osc_clk), .rst(1'b0), .d(rst), .q(rst_o)
  );

  rps_sync #(.W(3)) u_ctl_sync (
    .clk(osc_clk), .rst(rst_o), .d({clr, up, en}), .q(ctl_s)
  );

  always_ff @(posedge osc_clk) begin
    if (rst_o || ctl_s[2]) begin
      cnt <= '0;
    end else if (ctl_s[0]) begin
      if (ctl_s[1]) cnt <= cnt + 1'b1;
      else          cnt <= cnt - 1'b1;
    end
  end

  assign sign = cnt[CNT_W-1];
endmodule

// File: rtl/ro_pair_sequencer.sv
module ro_pair_sequencer
  import ro_pair_sequencer_pkg::*;
#(
  parameter int              WIN_W     = 16,
  parameter int              STEP_W    = 8,
  parameter int              CNT_W     = 20,
  parameter int              SETTLE    = 24,
  parameter int              DEF_STEPS = 10,
  parameter logic [7:0]      ZERO_SUB  = 8'hB4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              load_mode,
  input  logic              ser_in,
  input  logic              bypass,
  input  logic [7:0]        chal_b,
  input  logic [STEP_W-1:0] step_cnt,
  input  logic [WIN_W-1:0]  win_len,
  input  logic              osc_clk,
  output logic              osc_en,
  output logic [7:0]        chal,
  output logic              busy,
  output logic              done,
  output logic              resp
);
  localparam int SET_W = $clog2(SETTLE + 1);
  localparam int WS_W  = (WIN_W > STEP_W) ? WIN_W : STEP_W;
  localparam int TMR_W = (WS_W > SET_W) ? WS_W : SET_W;
  localparam logic [TMR_W-1:0] SETTLE_M1 = TMR_W'(SETTLE - 1);

  seq_state_t st, st_n;
  logic [TMR_W-1:0]  tmr, tmr_n;
  logic [WIN_W-1:0]  win_q;
  logic [STEP_W-1:0] steps_q;
  logic              byp_q;
  logic [7:0]        chal_b_q;
  logic [TMR_W-1:0]  win_m1, steps_m1;
  logic              accept, fin, step_en, load_en, shift_en;
  logic              clr_q, up_q, osc_en_q, busy_q, done_q, resp_q;
  logic              sign_o, sign_s;

  assign win_m1   = (win_q == '0) ? '0 : TMR_W'(win_q - 1'b1);
  assign steps_m1 = TMR_W'(steps_q - 1'b1);
  assign shift_en = (st == ST_IDLE) && !start && load_mode;

  always_comb begin
    st_n    = st;
    tmr_n   = (tmr != '0) ? tmr - 1'b1 : tmr;
    accept  = 1'b0;
    fin     = 1'b0;
    step_en = 1'b0;
    load_en = 1'b0;
    case (st)
      ST_IDLE: if (start) begin
        st_n = ST_CLR; tmr_n = SETTLE_M1; accept = 1'b1;
      end
      ST_CLR: if (tmr == '0) begin
        st_n = ST_WIN_A; tmr_n = win_m1;
      end
      ST_WIN_A: if (tmr == '0) begin
        st_n = ST_GAP; tmr_n = SETTLE_M1;
      end
      ST_GAP: if (tmr == '0) begin
        st_n = ST_STEP; tmr_n = byp_q ? '0 : steps_m1;
      end
      ST_STEP: begin
        load_en = byp_q;
        step_en = !byp_q;
        if (tmr == '0) begin
          st_n = ST_SETB; tmr_n = SETTLE_M1;
        end
      end
      ST_SETB: if (tmr == '0) begin
        st_n = ST_WIN_B; tmr_n = win_m1;
      end
      ST_WIN_B: if (tmr == '0) begin
        st_n = ST_TAIL; tmr_n = SETTLE_M1;
      end
      ST_TAIL: if (tmr == '0) begin
        st_n = ST_IDLE; fin = 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      tmr      <= '0;
      win_q    <= '0;
      steps_q  <= '0;
      byp_q    <= 1'b0;
      chal_b_q <= '0;
      clr_q    <= 1'b0;
      up_q     <= 1'b1;
      osc_en_q <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      resp_q   <= 1'b0;
    end else begin
      st       <= st_n;
      tmr      <= tmr_n;
      if (accept) begin
        win_q    <= win_len;
        steps_q  <= (step_cnt == '0) ? STEP_W'(DEF_STEPS) : step_cnt;
        byp_q    <= bypass;
        chal_b_q <= chal_b;
      end
      clr_q    <= (st_n == ST_CLR);
      up_q     <= !(st_n inside {ST_STEP, ST_SETB, ST_WIN_B, ST_TAIL});
      osc_en_q <= (st_n == ST_WIN_A) || (st_n == ST_WIN_B);
      busy_q   <= (st_n != ST_IDLE);
      done_q   <= fin;
      if (fin) resp_q <= sign_s;
    end
  end

  rps_chal_reg #(.ZERO_SUB(ZERO_SUB)) u_chal (
    .clk(clk), .rst(rst), .shift_en(shift_en), .shift_bit(ser_in),
    .fix_en(accept), .step_en(step_en), .load_en(load_en),
    .load_val(chal_b_q), .q(chal)
  );

  rps_osc_counter #(.CNT_W(CNT_W)) u_cnt (
    .osc_clk(osc_clk), .rst(rst), .en(osc_en_q), .up(up_q),
    .clr(clr_q), .sign(sign_o)
  );

  rps_sync #(.W(1)) u_sign_sync (
    .clk(clk), .rst(rst), .d(sign_o), .q(sign_s)
  );

  assign osc_en = osc_en_q;
  assign busy   = busy_q;
  assign done   = done_q;
  assign resp   = resp_q;
endmodule

// File: rtl/ro_pair_sequencer_chk.sv
module ro_pair_sequencer_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       load_mode,
  input logic       ser_in,
  input logic       osc_en,
  input logic [7:0] chal,
  input logic       busy,
  input logic       done,
  input logic       resp
);
  assert_idle_en_low_R3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !osc_en);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_at_end_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_resp_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(resp));

  assert_chal_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (osc_en && $past(osc_en)) |-> $stable(chal));

  assert_serial_shift_R2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && load_mode && !busy && !start) |->
      chal == {$past(chal[6:0]), $past(ser_in)});
endmodule

bind ro_pair_sequencer ro_pair_sequencer_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .load_mode(load_mode),
  .ser_in(ser_in), .osc_en(osc_en), .chal(chal), .busy(busy),
  .done(done), .resp(resp)
);

// File: tb/ro_pair_sequencer_tb.sv
`timescale 1ns/1ps
module ro_pair_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, load_mode = 1'b0, ser_in = 1'b0, bypass = 1'b0;
  logic [7:0]  chal_b = '0, step_cnt = '0;
  logic [15:0] win_len = 16'd10;
  logic        osc_clk = 1'b0;
  logic        osc_en, busy, done, resp;
  logic [7:0]  chal;

  int checks = 0, failures = 0;
  logic clr_mon = 1'b0;
  int nruns, cur_len, lenA, lenB, ndone, bad_idle;
  logic [7:0] chA, chB;
  logic en_prev;

  // {first challenge, second challenge, window}
  localparam logic [23:0] VEC [5] = '{
    {8'h20, 8'h90, 8'd120}, {8'hC0, 8'h30, 8'd100}, {8'h55, 8'hAA, 8'd64},
    {8'hF0, 8'h08, 8'd200}, {8'h60, 8'hA0, 8'd90}
  };

  ro_pair_sequencer u_dut (
    .clk(clk), .rst(rst), .start(start), .load_mode(load_mode),
    .ser_in(ser_in), .bypass(bypass), .chal_b(chal_b), .step_cnt(step_cnt),
    .win_len(win_len), .osc_clk(osc_clk), .osc_en(osc_en), .chal(chal),
    .busy(busy), .done(done), .resp(resp)
  );

  always #2 clk = ~clk;
  // smaller challenge value = faster oscillator
  initial forever #(2.0 + 0.016 * real'(chal)) osc_clk = ~osc_clk;

  always @(negedge clk) begin
    if (clr_mon) begin
      nruns = 0; cur_len = 0; lenA = 0; lenB = 0; ndone = 0; chA = '0; chB = '0;
    end else begin
      if (osc_en) begin
        if (!en_prev) begin nruns++; cur_len = 0; end
        cur_len++;
        if (nruns == 1) begin lenA = cur_len; chA = chal; end
        if (nruns == 2) begin lenB = cur_len; chB = chal; end
      end
      if (done) ndone++;
    end
    if (osc_en && !busy) bad_idle++;
    en_prev = osc_en;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_step(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) v = {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
    return v;
  endfunction

  task automatic load_chal(input logic [7:0] v);
    @(negedge clk); #1 load_mode = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      ser_in = v[i];
      @(negedge clk); #1;
    end
    load_mode = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); #1 start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
  endtask

  task automatic begin_seq(input logic [7:0] a, input logic [7:0] b,
                           input logic byp, input logic [7:0] st, input logic [15:0] w);
    bypass = byp; chal_b = b; step_cnt = st; win_len = w;
    load_chal(a);
    @(negedge clk); #1 clr_mon = 1'b1;
    @(negedge clk); #1 clr_mon = 1'b0;
    pulse_start();
  endtask

  task automatic wait_done();
    int n = 0;
    while (ndone == 0 && n < 8000) begin @(negedge clk); n++; end
  endtask

  initial begin
    en_prev = 1'b0; bad_idle = 0; nruns = 0; ndone = 0;
    repeat (6) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 osc_en", osc_en, 0); chk("R1 busy", busy, 0);
    chk("R1 done", done, 0); chk("R1 resp", resp, 0); chk("R1 chal", chal, 0);

    load_chal(8'hA7);
    @(negedge clk);
    chk("R2 serial load", chal, 8'hA7);
    chk("R3 enable low while loading", bad_idle, 0);

    // table of bypass pairs: both orderings of fast/slow
    foreach (VEC[k]) begin
      logic [7:0] a, b, w;
      {a, b, w} = VEC[k];
      begin_seq(a, b, 1'b1, 8'd3, {8'd0, w});
      wait_done();
      chk("R7 one done", ndone, 1);
      chk("R4 window A length", lenA, int'(w));
      chk("R4 first challenge", chA, a);
      chk("R6 window B length", lenB, int'(w));
      chk("R8 bypass second challenge", chB, b);
      chk("R7 response sign", resp, (b < a) ? 1 : 0);
    end

    // stepped second challenge
    begin_seq(8'h3C, 8'h00, 1'b0, 8'd5, 16'd80);
    wait_done();
    chk("R5 five steps", chB, ref_step(8'h3C, 5));
    chk("R6 stepped window length", lenB, 80);
    if ((chB > chA ? chB - chA : chA - chB) >= 40)
      chk("R7 stepped response", resp, (chB < chA) ? 1 : 0);

    begin_seq(8'h81, 8'h00, 1'b0, 8'd0, 16'd40);
    wait_done();
    chk("R5 zero steps means ten", chB, ref_step(8'h81, 10));

    // lock-up guard
    begin_seq(8'h00, 8'h00, 1'b0, 8'd3, 16'd40);
    wait_done();
    chk("R9 zero replaced", chA, 8'hB4);
    chk("R9 stepped from replacement", chB, ref_step(8'hB4, 3));

    // start while busy
    begin_seq(8'h20, 8'hD0, 1'b1, 8'd1, 16'd50);
    repeat (20) @(negedge clk);
    pulse_start();
    repeat (60) @(negedge clk);
    pulse_start();
    wait_done();
    repeat (200) @(negedge clk);
    chk("R10 two windows", nruns, 2);
    chk("R10 one done", ndone, 1);
    chk("R10 busy idle after", busy, 0);

    // serial activity and setup changes while busy
    begin_seq(8'h70, 8'h11, 1'b0, 8'd7, 16'd60);
    repeat (30) @(negedge clk);
    #1 load_mode = 1'b1; win_len = 16'd9; bypass = 1'b1; step_cnt = 8'd2;
    for (int i = 0; i < 30; i++) begin ser_in = i[0]; @(negedge clk); #1; end
    load_mode = 1'b0;
    wait_done();
    chk("R11 first challenge kept", chA, 8'h70);
    chk("R11 second challenge unaffected", chB, ref_step(8'h70, 7));
    chk("R12 window length captured", lenB, 60);

    // zero window acts as one
    begin_seq(8'h30, 8'hC0, 1'b1, 8'd1, 16'd0);
    wait_done();
    chk("R4 zero window A", lenA, 1);
    chk("R6 zero window B", lenB, 1);

    // response hold
    begin
      logic r0;
      begin_seq(8'hE0, 8'h10, 1'b1, 8'd1, 16'd100);
      wait_done();
      r0 = resp;
      chk("R7 fast second path", r0, 1);
      repeat (100) @(negedge clk);
      chk("R7 response held", resp, r0);
    end
    chk("R3 enable never high while idle", bad_idle, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(150000 * 4);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule